// File: doc/BRIEF.md
# Configurable LUT Logic Slice

This block models one programmable logic slice built from two 4-input lookup tables. The tables and the slice settings are loaded bit by bit through a configuration shift chain. After loading, the slice can evaluate two independent 4-input functions, or fuse both tables through a 2:1 selector into a single 5-input function. It can also treat the tables as a small distributed RAM, organised either as 16 words of 2 bits or as 32 words of 1 bit.

A dedicated two-bit ripple carry path uses the table outputs as propagate terms, so a pair of XOR tables gives a two-bit adder slice with carry-in and carry-out. Each of the two outputs can be taken directly from the logic or from a register that samples it on every clock edge.

Top module: `lut_slice`

## Requirements
- R1: While `cfg_en` is high, each rising clock edge shifts `cfg_din` into chain bit 36 and moves every chain bit down by one position. After 37 shifts, the first bit sent sits in bit 0. Chain layout: bits 15:0 are table A (bit i is the entry for address i), bits 31:16 are table B, bits 33:32 are the mode, bit 34 is the register select for `y[0]`, bit 35 is the register select for `y[1]`, and bit 36 is the arithmetic enable.
- R2: In mode 2'b00 with arithmetic disabled, `y[0]` equals table A at address `a_in` and `y[1]` equals table B at address `b_in`.
- R3: In mode 2'b01, both outputs equal table B at address `a_in` when `sel5` is 1, and table A at address `a_in` when `sel5` is 0.
- R4: In mode 2'b10, `y[0]` reads table A and `y[1]` reads table B, both at address `a_in` and without waiting for a clock. A rising edge with `wr_en` high writes `wr_data[0]` into table A and `wr_data[1]` into table B at address `a_in`.
- R5: In mode 2'b11, both outputs read the word at address {`sel5`,`a_in`}, where `sel5`=1 selects table B. A rising edge with `wr_en` high writes `wr_data[0]` into that word only.
- R6: In modes 2'b00 and 2'b01, `wr_en` changes no table entry.
- R7: The carry path takes propagate terms pA = table A at `a_in` and pB = table B at `b_in`. It forms c1 = pA ? `cin` : `carry_di[0]` and `cout` = pB ? c1 : `carry_di[1]`. With both tables set to 16'h6666 (XOR of address bits 0 and 1), {`cout`,`y[1]`,`y[0]`} is the sum of the two 2-bit operands and `cin`.
- R8: In mode 2'b00 with arithmetic enabled, `y[0]` = pA XOR `cin` and `y[1]` = pB XOR c1.
- R9: When an output's register-select bit is 1, that output shows the value its logic had at the previous rising edge. When the bit is 0, the output follows the logic combinationally.
- R10: A synchronous reset clears both output registers and leaves the table contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset of the output registers |
| cfg_en | input | 1 | Shift the configuration chain |
| cfg_din | input | 1 | Serial configuration data |
| a_in | input | 4 | Table A address; shared RAM address |
| b_in | input | 4 | Table B address in logic modes |
| sel5 | input | 1 | Fifth input / table select |
| wr_en | input | 1 | RAM write enable |
| wr_data | input | 2 | RAM write data |
| carry_di | input | 2 | Carry data taken when propagate is low |
| cin | input | 1 | Carry in |
| cout | output | 1 | Carry out |
| y | output | 2 | Slice outputs |

## Verification
The bench builds the slice with its default of four table inputs. This gives a 37-bit chain and 16-entry tables, small enough to read back every address in both RAM organisations. It also makes every operand pair of the two-bit adder reachable exhaustively. Three logic configurations are walked against a shared stimulus table. Directed cases then cover writes that must be ignored, the registered output path, and reset that keeps the tables.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
  localparam int SLICE_BITS = 2;

  typedef enum logic [1:0] {
    MODE_DUAL4   = 2'b00,
    MODE_FUSE5   = 2'b01,
    MODE_RAM16X2 = 2'b10,
    MODE_RAM32X1 = 2'b11
  } slice_mode_e;

  // carry mux: pass carry when propagating, else take data input
  function automatic logic carry_step(input logic prop, input logic c_in, input logic di);
    return prop ? c_in : di;
  endfunction

  function automatic logic sum_step(input logic prop, input logic c_in);
    return prop ^ c_in;
  endfunction

  function automatic logic tbl_pick(input logic hi, input logic lo_bit, input logic hi_bit);
    return hi ? hi_bit : lo_bit;
  endfunction
endpackage

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain
  import lut_slice_pkg::*;
#(
  parameter int LUT_INPUTS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_en,
  input  logic                         cfg_din,
  input  logic                         wr_en,
  input  logic [LUT_INPUTS-1:0]        wr_addr,
  input  logic                         wr_hi,
  input  logic [1:0]                   wr_data,
  output logic [(1<<LUT_INPUTS)-1:0]   tbl_a,
  output logic [(1<<LUT_INPUTS)-1:0]   tbl_b,
  output slice_mode_e                  mode,
  output logic [1:0]                   reg_sel,
  output logic                         arith
);
  localparam int DEPTH     = 1 << LUT_INPUTS;
  localparam int MODE_LSB  = 2 * DEPTH;
  localparam int RSEL_LSB  = MODE_LSB + 2;
  localparam int ARITH_BIT = RSEL_LSB + 2;
  localparam int CHAIN_LEN = ARITH_BIT + 1;

  logic [CHAIN_LEN-1:0] chain;
  logic we_a, we_b, bit_a, bit_b;

  assign tbl_a   = chain[DEPTH-1:0];
  assign tbl_b   = chain[2*DEPTH-1:DEPTH];
  assign mode    = slice_mode_e'(chain[MODE_LSB +: 2]);
  assign reg_sel = chain[RSEL_LSB +: 2];
  assign arith   = chain[ARITH_BIT];

  // write decode: only RAM modes, never while shifting
  always_comb begin
    we_a  = 1'b0;
    we_b  = 1'b0;
    bit_a = wr_data[0];
    bit_b = wr_data[0];
    if (!cfg_en && wr_en) begin
      case (mode)
        MODE_RAM16X2: begin
          we_a  = 1'b1;
          we_b  = 1'b1;
          bit_b = wr_data[1];
        end
        MODE_RAM32X1: begin
          we_a = !wr_hi;
          we_b = wr_hi;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_en) begin
      chain <= {cfg_din, chain[CHAIN_LEN-1:1]};
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (we_a && wr_addr == LUT_INPUTS'(i)) chain[i] <= bit_a;
        if (we_b && wr_addr == LUT_INPUTS'(i)) chain[DEPTH+i] <= bit_b;
      end
    end
  end

  p_shift_in_r1: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> chain[CHAIN_LEN-1] == $past(cfg_din));

  p_logic_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && !mode[1]) |=> $stable(chain));

  p_ram16_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && wr_en && mode == MODE_RAM16X2) |=>
      (tbl_a[$past(wr_addr)] == $past(wr_data[0])) &&
      (tbl_b[$past(wr_addr)] == $past(wr_data[1])));

  p_ram32_write_r5: assert property (@(posedge clk) disable iff (rst)
    (!cfg_en && wr_en && mode == MODE_RAM32X1 && wr_hi) |=>
      (tbl_b[$past(wr_addr)] == $past(wr_data[0])) && $stable(tbl_a));
endmodule

// File: rtl/lut_read.sv
module lut_read #(
  parameter int LUT_INPUTS = 4
) (
  input  logic [(1<<LUT_INPUTS)-1:0] tbl_a,
  input  logic [(1<<LUT_INPUTS)-1:0] tbl_b,
  input  logic [LUT_INPUTS-1:0]      a_in,
  input  logic [LUT_INPUTS-1:0]      b_in,
  output logic [1:0]                 prop,
  output logic                       hi_at_a
);
  // asynchronous table reads
  assign prop[0] = tbl_a[a_in];
  assign prop[1] = tbl_b[b_in];
  assign hi_at_a = tbl_b[a_in];
endmodule

// File: rtl/lut_carry_chain.sv
module lut_carry_chain
  import lut_slice_pkg::*;
#(
  parameter int BITS = SLICE_BITS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cin,
  input  logic [BITS-1:0] prop,
  input  logic [BITS-1:0] di,
  output logic [BITS-1:0] sum,
  output logic            cout
);
  logic [BITS:0] carry;

  assign carry[0] = cin;
  for (genvar g = 0; g < BITS; g++) begin : g_bit
    assign carry[g+1] = carry_step(prop[g], carry[g], di[g]);
    assign sum[g]     = sum_step(prop[g], carry[g]);
  end
  assign cout = carry[BITS];

  p_carry_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (&prop) |-> cout == cin);

  p_carry_kill_r7: assert property (@(posedge clk) disable iff (rst)
    (~|prop) |-> cout == di[BITS-1]);
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage
  import lut_slice_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  slice_mode_e mode,
  input  logic        arith,
  input  logic [1:0]  reg_sel,
  input  logic [1:0]  prop,
  input  logic        hi_at_a,
  input  logic        sel5,
  input  logic [1:0]  sum,
  output logic [1:0]  y
);
  logic [1:0] v;
  logic [1:0] q;
  logic       fused;

  assign fused = tbl_pick(sel5, prop[0], hi_at_a);

  always_comb begin
    case (mode)
      MODE_DUAL4:   v = arith ? sum : prop;
      MODE_RAM16X2: v = {hi_at_a, prop[0]};
      default:      v = {fused, fused};
    endcase
  end

  for (genvar g = 0; g < 2; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) q[g] <= 1'b0;
      else     q[g] <= v[g];
    end
    assign y[g] = reg_sel[g] ? q[g] : v[g];
  end

  p_reg_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q == $past(v));

  p_fuse_mirror_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_FUSE5 || mode == MODE_RAM32X1) |-> v[0] == v[1]);
endmodule

// File: rtl/lut_slice.sv
module lut_slice
  import lut_slice_pkg::*;
#(
  parameter int LUT_INPUTS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_en,
  input  logic                  cfg_din,
  input  logic [LUT_INPUTS-1:0] a_in,
  input  logic [LUT_INPUTS-1:0] b_in,
  input  logic                  sel5,
  input  logic                  wr_en,
  input  logic [1:0]            wr_data,
  input  logic [1:0]            carry_di,
  input  logic                  cin,
  output logic                  cout,
  output logic [1:0]            y
);
  localparam int DEPTH = 1 << LUT_INPUTS;

  logic [DEPTH-1:0] tbl_a, tbl_b;
  slice_mode_e      mode;
  logic [1:0]       reg_sel;
  logic             arith;
  logic [1:0]       prop;
  logic             hi_at_a;
  logic [1:0]       sum;

  lut_cfg_chain #(.LUT_INPUTS(LUT_INPUTS)) u_chain (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .wr_en(wr_en), .wr_addr(a_in), .wr_hi(sel5), .wr_data(wr_data),
    .tbl_a(tbl_a), .tbl_b(tbl_b), .mode(mode), .reg_sel(reg_sel), .arith(arith)
  );

  lut_read #(.LUT_INPUTS(LUT_INPUTS)) u_read (
    .tbl_a(tbl_a), .tbl_b(tbl_b), .a_in(a_in), .b_in(b_in),
    .prop(prop), .hi_at_a(hi_at_a)
  );

  lut_carry_chain #(.BITS(SLICE_BITS)) u_carry (
    .clk(clk), .rst(rst), .cin(cin), .prop(prop), .di(carry_di),
    .sum(sum), .cout(cout)
  );

  lut_out_stage u_out (
    .clk(clk), .rst(rst), .mode(mode), .arith(arith), .reg_sel(reg_sel),
    .prop(prop), .hi_at_a(hi_at_a), .sel5(sel5), .sum(sum), .y(y)
  );
endmodule

// File: tb/lut_slice_tb_top.sv
module lut_slice_tb_top;
  logic clk = 1'b0;
  logic rst, cfg_en, cfg_din, sel5, wr_en, cin, cout;
  logic [3:0] a_in, b_in;
  logic [1:0] wr_data, carry_di, y;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] t_a, t_b;
  logic [1:0]  m_mode;
  logic        m_arith;

  // stimulus: [3:0] a, [7:4] b, [8] sel5, [9] cin, [11:10] carry_di
  localparam logic [11:0] VEC [10] = '{12'h000, 12'hFFF, 12'h5A3, 12'hA5C, 12'h31E,
                                       12'hC72, 12'h6B9, 12'h9D4, 12'h2E7, 12'hE18};

  always #2 clk = ~clk;

  lut_slice dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .a_in(a_in), .b_in(b_in),
    .sel5(sel5), .wr_en(wr_en), .wr_data(wr_data), .carry_di(carry_di), .cin(cin),
    .cout(cout), .y(y)
  );

  // returns {cout, y1, y0} from the requirements
  function automatic logic [2:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic s, input logic ci, input logic [1:0] di);
    logic pa, pb, c1, co, o0, o1;
    pa = t_a[a];
    pb = t_b[b];
    c1 = pa ? ci : di[0];
    co = pb ? c1 : di[1];
    case (m_mode)
      2'b00: begin o0 = m_arith ? (pa ^ ci) : pa; o1 = m_arith ? (pb ^ c1) : pb; end
      2'b10: begin o0 = t_a[a]; o1 = t_b[a]; end
      default: begin o0 = s ? t_b[a] : t_a[a]; o1 = o0; end
    endcase
    return {co, o1, o0};
  endfunction

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] ta, input logic [15:0] tb, input logic [1:0] md,
                      input logic [1:0] rs, input logic ar);
    logic [36:0] w;
    w = {ar, rs, md, tb, ta};
    @(negedge clk);
    cfg_en = 1'b1;
    for (int i = 0; i < 37; i++) begin
      cfg_din = w[i];
      @(negedge clk);
    end
    cfg_en = 1'b0;
    t_a = ta; t_b = tb; m_mode = md; m_arith = ar;
  endtask

  task automatic apply(input logic [11:0] v);
    @(negedge clk);
    a_in = v[3:0]; b_in = v[7:4]; sel5 = v[8]; cin = v[9]; carry_di = v[11:10];
    #1;
  endtask

  task automatic ram_wr(input logic [3:0] ad, input logic hi, input logic [1:0] d);
    @(negedge clk);
    a_in = ad; sel5 = hi; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic walk(input string req);
    for (int k = 0; k < 10; k++) begin
      apply(VEC[k]);
      chk(req, {cout, y}, model(VEC[k][3:0], VEC[k][7:4], VEC[k][8], VEC[k][9], VEC[k][11:10]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] m0, m1;
    rst = 1'b1; cfg_en = 1'b0; cfg_din = 1'b0; a_in = '0; b_in = '0; sel5 = 1'b0;
    wr_en = 1'b0; wr_data = '0; carry_di = '0; cin = 1'b0;

    // R1 load under reset; R10 registers stay clear; R9 registered outputs
    load(16'hFFFF, 16'hFFFF, 2'b00, 2'b11, 1'b0);
    #1 chk("R10 reset clears registers", {1'b0, y}, 3'b000);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    chk("R9 R1 registered after reset", {1'b0, y}, 3'b011);

    // R2 dual 4-input, R7 carry
    load(16'hA5C3, 16'h6996, 2'b00, 2'b00, 1'b0);
    walk("R2 R7 dual mode");
    // R3 fused 5-input
    load(16'hA5C3, 16'h6996, 2'b01, 2'b00, 1'b0);
    walk("R3 fused mode");
    // R8 arithmetic outputs
    load(16'h6666, 16'h6666, 2'b00, 2'b00, 1'b1);
    walk("R8 arith mode");

    // R7 exhaustive 2-bit add: a_in={y0,x0}, b_in={y1,x1}, carry_di=x
    for (int x = 0; x < 4; x++)
      for (int z = 0; z < 4; z++)
        for (int c = 0; c < 2; c++) begin
          @(negedge clk);
          a_in = {2'b00, z[0], x[0]}; b_in = {2'b00, z[1], x[1]};
          carry_di = x[1:0]; cin = c[0]; sel5 = 1'b0;
          #1 chk("R7 add", {cout, y}, 3'(x + z + c));
        end

    // R4 16x2 RAM
    load(16'h0000, 16'h0000, 2'b10, 2'b00, 1'b0);
    ram_wr(4'd3, 1'b0, 2'b10);  t_b[3] = 1'b1;
    ram_wr(4'd12, 1'b0, 2'b01); t_a[12] = 1'b1;
    ram_wr(4'd15, 1'b0, 2'b11); t_a[15] = 1'b1; t_b[15] = 1'b1;
    for (int i = 0; i < 16; i++) begin
      apply({4'h0, 4'h0, 4'(i)});
      chk("R4 ram16x2 read", {cout, y}, model(4'(i), 4'h0, 1'b0, 1'b0, 2'b00));
    end

    // R5 32x1 RAM
    load(16'h00FF, 16'hF0F0, 2'b11, 2'b00, 1'b0);
    ram_wr(4'd5, 1'b1, 2'b01); t_b[5] = 1'b1;
    ram_wr(4'd5, 1'b0, 2'b10); t_a[5] = 1'b0;
    for (int i = 0; i < 32; i++) begin
      apply({2'b00, 1'b0, i[4], 4'h0, 4'(i)});
      chk("R5 ram32x1 read", {cout, y}, model(4'(i), 4'h0, i[4], 1'b0, 2'b00));
    end

    // R6 writes ignored in logic modes
    load(16'hA5C3, 16'h6996, 2'b00, 2'b00, 1'b0);
    @(negedge clk); b_in = 4'd0;
    ram_wr(4'd2, 1'b0, 2'b11);
    apply(12'h002);
    chk("R6 dual ignores write", {cout, y}, model(4'd2, 4'd0, 1'b0, 1'b0, 2'b00));
    load(16'hA5C3, 16'h6996, 2'b01, 2'b00, 1'b0);
    ram_wr(4'd2, 1'b0, 2'b11);
    ram_wr(4'd0, 1'b1, 2'b11);
    apply(12'h002);
    chk("R6 fused ignores write lo", {cout, y}, model(4'd2, 4'd0, 1'b0, 1'b0, 2'b00));
    apply(12'h100);
    chk("R6 fused ignores write hi", {cout, y}, model(4'd0, 4'd0, 1'b1, 1'b0, 2'b00));

    // R9 y0 registered, y1 combinational
    load(16'hA5C3, 16'h6996, 2'b00, 2'b01, 1'b0);
    apply(VEC[2]);
    m0 = model(VEC[2][3:0], VEC[2][7:4], VEC[2][8], VEC[2][9], VEC[2][11:10]);
    apply(VEC[3]);
    m1 = model(VEC[3][3:0], VEC[3][7:4], VEC[3][8], VEC[3][9], VEC[3][11:10]);
    chk("R9 mixed register select", {cout, y}, {m1[2], m1[1], m0[0]});

    // R10 reset leaves tables intact
    load(16'hA5C3, 16'h6996, 2'b00, 2'b00, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      apply(VEC[k]);
      chk("R10 tables kept over reset", {cout, y},
          model(VEC[k][3:0], VEC[k][7:4], VEC[k][8], VEC[k][9], VEC[k][11:10]));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule